// File: doc/BRIEF.md
# Single-Wire Slave Time-Slot Engine

This block is the bit-level front end of a slave on a single-wire, open-drain bus. The line is shared with a master and possibly other slaves. The master starts every exchange with a long low pulse, which resets the bus. Between resets the master sends bits and asks for bits in time slots, and each slot starts with a falling edge. The block passes the line through a two-flop synchroniser. It times every low and high period against a one-microsecond tick, which it derives from the system clock.

For the layer above, the block provides three things:
- a one-cycle strobe for each bit received in a master write slot, with the bit value;
- a handshake that hands one bit over for the next read slot;
- a one-cycle event when it detects a bus reset.

The only connection back to the line is a pull-low enable. The block either pulls the line low or releases it and never drives it high. Several devices on the line therefore combine as a wired-AND. The block pulls the line low in two cases: to send its presence pulse after a full reset, and to stretch the low phase of a read slot when it sends a zero.

Top module: `sw_slot_phy`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `line_pull`, `rx_valid`, `tx_ack` and `reset_seen` are all 0.
- R2: A low of at least 480 µs, followed by a rise, produces a one-cycle `reset_seen` pulse. After the rise, `line_pull` goes to 1 after a delay of 15 to 60 µs and stays at 1 for 60 to 240 µs. The nominal values are 20 µs and 120 µs.
- R3: A low that lasts longer than 120 µs but less than 480 µs has three effects: it produces one `reset_seen` pulse when the line rises, it causes no presence pulse, and it releases any pull the block had started. This holds even when the low began as a read slot.
- R4: A falling edge with `tx_req` at 0 starts a write slot. The block samples the line 30 µs after the edge and gives exactly one one-cycle `rx_valid` pulse. `rx_bit` is 1 if the line was high at the sample point and 0 if it was low.
- R5: A falling edge with `tx_req` at 1 starts a read slot. The block takes `tx_bit` and pulses `tx_ack` for one cycle. A read slot never produces `rx_valid`. When `tx_bit` is 0, `line_pull` is 1 from just after the edge until 45 µs after it, so it is still 1 at 15 µs and 0 at 60 µs. When `tx_bit` is 1, `line_pull` stays 0.
- R6: A falling edge that arrives while the block is waiting to send, or is sending, its presence pulse is ignored. It produces no `rx_valid` and no `tx_ack`, even with `tx_req` at 1.
- R7: `rx_valid`, `tx_ack` and `reset_seen` are each one cycle wide. `rx_valid` and `tx_ack` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the shared line (asynchronous) |
| line_pull | output | 1 | 1 = pull the line low, 0 = release |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit was received |
| rx_bit | output | 1 | Received bit value, valid with `rx_valid` |
| tx_req | input | 1 | The upper layer has a bit for the next read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_ack | output | 1 | One-cycle strobe: `tx_bit` was taken at slot start |
| reset_seen | output | 1 | One-cycle strobe: a bus reset or a long-low abort ended |

## Verification
The bench builds the block with `CLKS_PER_US` set to 4. This makes a 480 µs reset about 1,920 clock cycles long, so several full resets, presence pulses and slots fit in a short run. All timing parameters keep their microsecond defaults. The bench can therefore measure presence delay and width, the write sample point and the read-zero hold against the real microsecond windows. It also reaches the boundary between an aborted low of 200 µs and a full reset of 500 µs.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SLOT     = 3'd1,
    ST_WAIT_HI  = 3'd2,
    ST_PRES_DLY = 3'd3,
    ST_PRES_LOW = 3'd4
  } slot_state_e;

endpackage

// File: rtl/sw_tick.sv
module sw_tick #(
  parameter int CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (CLKS_PER_US <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLKS_PER_US);
      logic [DW-1:0] div_q;
      logic          tick_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_q  <= '0;
          tick_q <= 1'b0;
        end else if (div_q == DW'(CLKS_PER_US - 1)) begin
          div_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          div_q  <= div_q + 1'b1;
          tick_q <= 1'b0;
        end
      end

      assign tick = tick_q;

      // R1: consecutive ticks are spaced by the divider
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/sw_sync.sv
module sw_sync (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic fall,
  output logic rise
);

  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level = stab_q;
  assign fall  = prev_q & ~stab_q;
  assign rise  = ~prev_q & stab_q;

endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
  import sw_pkg::*;
#(
  parameter int RST_LOW_US   = 480,
  parameter int ABORT_LOW_US = 120,
  parameter int PRES_DLY_US  = 20,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic level,
  input  logic fall,
  input  logic rise,
  input  logic tx_req,
  input  logic tx_bit,
  output logic pull,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_ack,
  output logic reset_seen
);

  localparam int MAXV = (RST_LOW_US > PRES_LOW_US) ? RST_LOW_US : PRES_LOW_US;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RST_LIM   = CW'(RST_LOW_US);
  localparam logic [CW-1:0] ABORT_LIM = CW'(ABORT_LOW_US + 1);
  localparam logic [CW-1:0] SAMP_LIM  = CW'(SAMPLE_US);
  localparam logic [CW-1:0] HOLD_LIM  = CW'(HOLD_US);
  localparam logic [CW-1:0] PDLY_LIM  = CW'(PRES_DLY_US);
  localparam logic [CW-1:0] PLOW_LIM  = CW'(PRES_LOW_US);
  localparam logic [CW-1:0] CNT_CAP   = CW'(MAXV);

  slot_state_e   state_q;
  logic [CW-1:0] slot_cnt_q;
  logic [CW-1:0] low_cnt_q;
  logic          is_read_q;
  logic          in_pres;
  logic          abort_low;

  assign in_pres   = (state_q == ST_PRES_DLY) || (state_q == ST_PRES_LOW);
  assign abort_low = (low_cnt_q >= ABORT_LIM);

  // Length of the current low period, in microsecond ticks (own presence excluded)
  always_ff @(posedge clk) begin
    if (rst || in_pres || level) begin
      low_cnt_q <= '0;
    end else if (tick && (low_cnt_q != RST_LIM)) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      slot_cnt_q <= '0;
      is_read_q  <= 1'b0;
      pull       <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      tx_ack     <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      tx_ack     <= 1'b0;
      reset_seen <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (abort_low) begin
            pull    <= 1'b0;
            state_q <= ST_WAIT_HI;
          end else if (fall) begin
            slot_cnt_q <= '0;
            state_q    <= ST_SLOT;
            is_read_q  <= tx_req;
            if (tx_req) begin
              tx_ack <= 1'b1;
              pull   <= ~tx_bit;
            end
          end
        end
        ST_SLOT: begin
          if (abort_low) begin
            pull    <= 1'b0;
            state_q <= ST_WAIT_HI;
          end else begin
            if (tick && (slot_cnt_q != CNT_CAP)) begin
              slot_cnt_q <= slot_cnt_q + 1'b1;
            end
            if (tick && (slot_cnt_q == SAMP_LIM - 1'b1) && !is_read_q) begin
              rx_valid <= 1'b1;
              rx_bit   <= level;
            end
            if (tick && (slot_cnt_q == HOLD_LIM - 1'b1)) begin
              pull <= 1'b0;
            end
            if ((slot_cnt_q >= SAMP_LIM) && !pull && level) begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WAIT_HI: begin
          if (rise) begin
            reset_seen <= 1'b1;
            slot_cnt_q <= '0;
            state_q    <= (low_cnt_q >= RST_LIM) ? ST_PRES_DLY : ST_IDLE;
          end
        end
        ST_PRES_DLY: begin
          if (tick) begin
            if (slot_cnt_q == PDLY_LIM - 1'b1) begin
              slot_cnt_q <= '0;
              pull       <= 1'b1;
              state_q    <= ST_PRES_LOW;
            end else begin
              slot_cnt_q <= slot_cnt_q + 1'b1;
            end
          end
        end
        ST_PRES_LOW: begin
          if (tick) begin
            if (slot_cnt_q == PLOW_LIM - 1'b1) begin
              pull    <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              slot_cnt_q <= slot_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: strobes are single-cycle and exclusive
  a_r7_rx_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && tx_ack));
  // R5: read-zero pull never outlasts the hold point
  a_r5_hold_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLOT && pull) |-> (slot_cnt_q <= HOLD_LIM));
  // R3: waiting out a long low, the line is released
  a_r3_release_wait: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_HI) |-> !pull);
  // R2: pull only starts for a read slot or the presence pulse
  a_r2_pull_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> (state_q == ST_SLOT || state_q == ST_PRES_LOW));
  // R6: no bit traffic while presence is pending or active
  a_r6_pres_quiet: assert property (@(posedge clk) disable iff (rst)
    in_pres |-> (!tx_ack && !rx_valid));

endmodule

// File: rtl/sw_slot_phy.sv
module sw_slot_phy #(
  parameter int CLKS_PER_US  = 100,
  parameter int RST_LOW_US   = 480,
  parameter int ABORT_LOW_US = 120,
  parameter int PRES_DLY_US  = 20,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_pull,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_req,
  input  logic tx_bit,
  output logic tx_ack,
  output logic reset_seen
);

  logic tick, level, fall, rise;

  sw_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  sw_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (line_in),
    .level(level),
    .fall (fall),
    .rise (rise)
  );

  sw_slot_fsm #(
    .RST_LOW_US  (RST_LOW_US),
    .ABORT_LOW_US(ABORT_LOW_US),
    .PRES_DLY_US (PRES_DLY_US),
    .PRES_LOW_US (PRES_LOW_US),
    .SAMPLE_US   (SAMPLE_US),
    .HOLD_US     (HOLD_US)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .level     (level),
    .fall      (fall),
    .rise      (rise),
    .tx_req    (tx_req),
    .tx_bit    (tx_bit),
    .pull      (line_pull),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_ack    (tx_ack),
    .reset_seen(reset_seen)
  );

endmodule

// File: tb/sw_slot_phy_test.sv
module sw_slot_phy_test;

  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_pull = 1'b0;
  logic tx_req = 1'b0;
  logic tx_bit = 1'b1;
  logic line_in;
  logic line_pull, rx_valid, rx_bit, tx_ack, reset_seen;

  int total = 0;
  int fails = 0;
  int rx_cnt = 0;
  int ack_cnt = 0;
  int rst_cnt = 0;
  int pull_rises = 0;
  logic prev_pull = 1'b0;
  logic [63:0] rx_log = '0;

  always #5 clk = ~clk;

  assign line_in = ~(m_pull | line_pull);

  sw_slot_phy #(.CLKS_PER_US(DIV)) uut (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .line_pull (line_pull),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_req    (tx_req),
    .tx_bit    (tx_bit),
    .tx_ack    (tx_ack),
    .reset_seen(reset_seen)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_log[rx_cnt[5:0]] <= rx_bit;
        rx_cnt <= rx_cnt + 1;
      end
      if (tx_ack) ack_cnt <= ack_cnt + 1;
      if (reset_seen) rst_cnt <= rst_cnt + 1;
      if (line_pull && !prev_pull) pull_rises <= pull_rises + 1;
      prev_pull <= line_pull;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic us(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(line_pull == 1'b0 && rx_valid == 1'b0, "R1 idle outputs", {line_pull, rx_valid}, 0);
    check(tx_ack == 1'b0 && reset_seen == 1'b0, "R1 strobes", {tx_ack, reset_seen}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(line_pull == 1'b0 && reset_seen == 1'b0, "R1 first cycle", {line_pull, reset_seen}, 0);
  endtask

  task automatic t_full_reset();
    int r0, d, w;
    r0 = rst_cnt;
    m_pull = 1'b1; us(500); m_pull = 1'b0;
    d = 0;
    while (!line_pull && d < 100 * DIV) begin @(negedge clk); d++; end
    w = 0;
    while (line_pull && w < 300 * DIV) begin @(negedge clk); w++; end
    check(rst_cnt == r0 + 1, "R2 reset_seen count", rst_cnt - r0, 1);
    check(d >= 15 * DIV && d <= 60 * DIV, "R2 presence delay cycles", d, 20 * DIV);
    check(w >= 60 * DIV && w <= 240 * DIV, "R2 presence width cycles", w, 120 * DIV);
    us(10);
  endtask

  task automatic t_short_low();
    int r0, p0;
    r0 = rst_cnt; p0 = pull_rises;
    m_pull = 1'b1; us(200); m_pull = 1'b0;
    us(300);
    check(rst_cnt == r0 + 1, "R3 reset_seen on abort", rst_cnt - r0, 1);
    check(pull_rises == p0, "R3 no presence", pull_rises - p0, 0);
  endtask

  task automatic t_write_bits(input logic [5:0] pat);
    int c0;
    c0 = rx_cnt;
    for (int i = 0; i < 6; i++) begin
      m_pull = 1'b1;
      if (pat[i]) begin us(5); m_pull = 1'b0; us(60); end
      else begin us(65); m_pull = 1'b0; end
      us(5);
    end
    check(rx_cnt == c0 + 6, "R4 one strobe per slot (R7 width)", rx_cnt - c0, 6);
    for (int i = 0; i < 6; i++)
      check(rx_log[c0 + i] == pat[i], "R4 bit value", int'(rx_log[c0 + i]), int'(pat[i]));
  endtask

  task automatic t_read_bit(input logic b);
    int a0, c0;
    a0 = ack_cnt; c0 = rx_cnt;
    tx_req = 1'b1; tx_bit = b;
    m_pull = 1'b1; us(2); m_pull = 1'b0; tx_req = 1'b0;
    us(13);
    check(line_pull == !b, "R5 pull at 15us", line_pull, !b);
    us(45);
    check(line_pull == 1'b0, "R5 released at 60us", line_pull, 0);
    us(5);
    check(ack_cnt == a0 + 1, "R5 tx_ack once (R7)", ack_cnt - a0, 1);
    check(rx_cnt == c0, "R5 no rx in read slot", rx_cnt - c0, 0);
  endtask

  task automatic t_pres_ignore();
    int a0, c0;
    m_pull = 1'b1; us(500); m_pull = 1'b0;
    tx_req = 1'b1; tx_bit = 1'b0;
    a0 = ack_cnt; c0 = rx_cnt;
    us(30);
    m_pull = 1'b1; us(5); m_pull = 1'b0;
    us(200);
    check(ack_cnt == a0, "R6 no ack during presence", ack_cnt - a0, 0);
    check(rx_cnt == c0, "R6 no rx during presence", rx_cnt - c0, 0);
    tx_req = 1'b0;
    us(5);
  endtask

  task automatic t_abort_read();
    int r0, p0, a0;
    r0 = rst_cnt; a0 = ack_cnt;
    tx_req = 1'b1; tx_bit = 1'b0;
    m_pull = 1'b1; us(2); tx_req = 1'b0;
    p0 = pull_rises;
    us(198); m_pull = 1'b0;
    us(300);
    check(ack_cnt == a0 + 1, "R3 read slot started", ack_cnt - a0, 1);
    check(rst_cnt == r0 + 1, "R3 abort reset_seen", rst_cnt - r0, 1);
    check(pull_rises == p0 && line_pull == 1'b0, "R3 released, no presence", pull_rises - p0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    us(5);
    t_full_reset();
    t_write_bits(6'b101001);
    t_write_bits(6'b010110);
    t_read_bit(1'b0);
    t_read_bit(1'b1);
    t_short_low();
    t_pres_ignore();
    t_abort_read();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule